// File: doc/BRIEF.md
# Frame Schedule Walker

This block walks the per-frame work schedule that software leaves in memory. On every frame tick it reads one word of a frame list, indexed by a frame counter, and then follows chains of queue heads and transfer descriptors through a single-word memory port. Each descriptor that is marked active is handed to an external transaction executor. When the executor reports back, the walker decides whether the owning queue moves forward and writes the new top element into that queue head.

A queue head carries two link words: a horizontal link to the next piece of work in the frame and an element link to the top member of its queue. The walker keeps the most recently entered queue head as its context. When a descriptor succeeds, the walker writes that descriptor's link word into the context's element word. A per-descriptor flag then selects whether the walk goes down the same queue (depth-first) or across to the next horizontal item (breadth-first). Failed and inactive descriptors never advance their queue, and the walk always continues across from them. A new frame tick abandons any walk still in progress.

Top module: `sched_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_rd_en`, `mem_wr_en` and `exec_start` are low and `frame_num` is 0.
- R2: Each `frame_tick` reads the frame-list word at byte address FL_BASE + 4*n, where n is the frame index. The index walked is shown on `frame_num`. It starts at 0 and steps by one per tick, wrapping to 0 after FL_ENTRIES-1. A frame-list word with bit 0 set ends the frame at once.
- R3: Every link word is decoded as follows: the byte address of the target is bits [AW-1:4] with the low four bits zero, bit 1 set means the target is a queue head (clear means a descriptor), and bit 0 set means the link is invalid.
- R4: A queue head is two words: word 0 is the horizontal link and word 1 (address +4) is the element link. If the element link has bit 0 set, the queue is empty and the walk follows the horizontal link. If a horizontal link has bit 0 set, the frame is finished.
- R5: A descriptor is two words: word 0 is its link word and word 1 holds the active flag in bit 23. A descriptor with bit 23 clear is not sent to the executor, its queue does not advance, and the walk continues as if it had failed.
- R6: For an active descriptor, `exec_start` pulses for one cycle with the descriptor's byte address on `exec_td_addr`. The walker then waits for `exec_done`, and `exec_ok` tells it whether the transaction succeeded.
- R7: On success inside a queue, the walker writes the descriptor's link word into word 1 of the current queue-head context (a single one-cycle write).
- R8: After a successful write-back, if the descriptor's link word has bit 2 set and bit 0 clear, the walker goes on to that link inside the same queue. Otherwise it takes the context's horizontal link.
- R9: On failure, the walker writes nothing and follows the context's horizontal link, whatever bit 2 says.
- R10: If an element link points at another queue head, that head becomes the context and later write-backs go to it. The outer head's element word is left unchanged.
- R11: A descriptor reached from the frame list or from a horizontal link has no queue context. It is never written back, and after it the walk follows its own link word.
- R12: A `frame_tick` arriving during a walk abandons it, so the abandoned walk does no further execution or write. The walker restarts at the next frame-list entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle frame start strobe |
| mem_rd_en | output | 1 | Read strobe. The memory registers the word on the edge that samples it, and the walker consumes it on the following edge |
| mem_wr_en | output | 1 | Write strobe, one cycle |
| mem_addr | output | AW | Byte address of the word to read or write |
| mem_wdata | output | 32 | Write data (a link word) |
| mem_rdata | input | 32 | Read data from memory |
| exec_start | output | 1 | One-cycle request to run a descriptor |
| exec_td_addr | output | AW | Byte address of the descriptor to run |
| exec_done | input | 1 | Executor completion strobe |
| exec_ok | input | 1 | Completion status, valid with exec_done (1 = success) |
| busy | output | 1 | A walk is in progress |
| frame_num | output | $clog2(FL_ENTRIES) | Index of the frame being walked |

## Verification
The bench builds the walker with FL_ENTRIES = 8 and AW = 16. With these values the frame counter wraps after eight ticks, so later frames walk queues whose element words earlier frames have already rewritten. The 16-bit address space lets a 256-word memory image hold the whole schedule, including nested queue heads, a horizontal chain and frame-level descriptors. A longer executor delay opens a window that is wide enough to land a frame tick in the middle of a transaction.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int WORD_W  = 32;
  localparam int LNK_T   = 0;   // link invalid
  localparam int LNK_Q   = 1;   // target is a queue head
  localparam int LNK_VF  = 2;   // depth-first after success
  localparam int ACT_BIT = 23;  // descriptor active flag

  typedef enum logic [2:0] {
    S_IDLE, S_FL, S_QH0, S_QH1, S_TD0, S_TD1, S_EXEC, S_WB
  } walk_st_t;
endpackage

// File: rtl/sw_link_decode.sv
module sw_link_decode
  import sw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [WORD_W-1:0] word,
  output logic [AW-1:0]     addr,
  output logic              is_qh,
  output logic              term
);
  assign addr  = {word[AW-1:4], 4'b0000};
  assign is_qh = word[LNK_Q];
  assign term  = word[LNK_T];
endmodule

// File: rtl/sw_frame_ctr.sv
module sw_frame_ctr #(
  parameter int N = 1024,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] fetch_idx,
  output logic [W-1:0] cur_idx
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_idx <= '0;
      cur_idx   <= '0;
    end else if (tick) begin
      cur_idx   <= fetch_idx;
      fetch_idx <= (fetch_idx == LAST) ? '0 : fetch_idx + 1'b1;
    end
  end
endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import sw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FL_ENTRIES = 1024,
  parameter int FL_BASE    = 0,
  localparam int FN_W      = $clog2(FL_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              exec_start,
  output logic [AW-1:0]     exec_td_addr,
  input  logic              exec_done,
  input  logic              exec_ok,
  output logic              busy,
  output logic [FN_W-1:0]   frame_num
);
  localparam logic [AW-1:0] WORD1 = AW'(4);
  localparam logic [AW-1:0] BASE  = AW'(FL_BASE);

  walk_st_t          state;
  logic              wt;        // read data not yet returned
  logic              in_q;      // walking inside a queue context
  logic [AW-1:0]     obj_addr;  // object currently being read
  logic [AW-1:0]     ctx_addr;  // queue head context
  logic [WORD_W-1:0] qh_horiz;
  logic [WORD_W-1:0] td_link;
  logic [FN_W-1:0]   fetch_idx;

  logic              jump_v, jump_inq;
  logic [WORD_W-1:0] jump_w;
  logic [AW-1:0]     dec_addr;
  logic              dec_qh, dec_term;

  sw_frame_ctr #(.N(FL_ENTRIES), .W(FN_W)) i_fctr (
    .clk(clk), .rst(rst), .tick(frame_tick),
    .fetch_idx(fetch_idx), .cur_idx(frame_num)
  );

  sw_link_decode #(.AW(AW)) i_dec (
    .word(jump_w), .addr(dec_addr), .is_qh(dec_qh), .term(dec_term)
  );

  // Which link word (if any) the walk follows this cycle.
  always_comb begin
    jump_v   = 1'b0;
    jump_inq = 1'b0;
    jump_w   = mem_rdata;
    unique case (state)
      S_FL:   jump_v = !wt;
      S_QH1: if (!wt) begin
        jump_v = 1'b1;
        if (!mem_rdata[LNK_T]) jump_inq = 1'b1;
        else                   jump_w   = qh_horiz;
      end
      S_TD1: if (!wt && !mem_rdata[ACT_BIT]) begin
        jump_v = 1'b1;
        jump_w = in_q ? qh_horiz : td_link;
      end
      S_EXEC: if (exec_done && !(exec_ok && in_q)) begin
        jump_v = 1'b1;
        jump_w = in_q ? qh_horiz : td_link;
      end
      S_WB: begin
        jump_v = 1'b1;
        if (td_link[LNK_VF] && !td_link[LNK_T]) begin
          jump_w   = td_link;
          jump_inq = 1'b1;
        end else begin
          jump_w = qh_horiz;
        end
      end
      default: jump_v = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      wt           <= 1'b0;
      in_q         <= 1'b0;
      obj_addr     <= '0;
      ctx_addr     <= '0;
      qh_horiz     <= '0;
      td_link      <= '0;
      mem_rd_en    <= 1'b0;
      mem_wr_en    <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      exec_start   <= 1'b0;
      exec_td_addr <= '0;
    end else begin
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      exec_start <= 1'b0;
      if (frame_tick) begin
        state     <= S_FL;
        mem_addr  <= BASE + AW'({fetch_idx, 2'b00});
        mem_rd_en <= 1'b1;
        wt        <= 1'b1;
        in_q      <= 1'b0;
      end else begin
        if (wt) wt <= 1'b0;
        unique case (state)
          S_QH0: if (!wt) begin
            qh_horiz  <= mem_rdata;
            mem_addr  <= obj_addr + WORD1;
            mem_rd_en <= 1'b1;
            wt        <= 1'b1;
            state     <= S_QH1;
          end
          S_QH1: if (!wt) ctx_addr <= obj_addr;
          S_TD0: if (!wt) begin
            td_link   <= mem_rdata;
            mem_addr  <= obj_addr + WORD1;
            mem_rd_en <= 1'b1;
            wt        <= 1'b1;
            state     <= S_TD1;
          end
          S_TD1: if (!wt && mem_rdata[ACT_BIT]) begin
            exec_start   <= 1'b1;
            exec_td_addr <= obj_addr;
            state        <= S_EXEC;
          end
          S_EXEC: if (exec_done && exec_ok && in_q) begin
            mem_wr_en <= 1'b1;
            mem_addr  <= ctx_addr + WORD1;
            mem_wdata <= td_link;
            state     <= S_WB;
          end
          default: ;
        endcase
        if (jump_v) begin
          if (dec_term) begin
            state <= S_IDLE;
          end else begin
            state     <= dec_qh ? S_QH0 : S_TD0;
            obj_addr  <= dec_addr;
            mem_addr  <= dec_addr;
            mem_rd_en <= 1'b1;
            wt        <= 1'b1;
            in_q      <= jump_inq;
          end
        end
      end
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int AW   = 32,
  parameter int FN_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_tick,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic [AW-1:0]   mem_addr,
  input logic            exec_start,
  input logic            busy,
  input logic [FN_W-1:0] frame_num
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!exec_start && !mem_wr_en)); // R1
  AST_TICK_READS: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> mem_rd_en); // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(frame_num)); // R2
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !frame_tick) |=> !mem_rd_en); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> busy); // R6
  AST_WB_ELEM_WORD: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_addr[3:0] == 4'h4)); // R7
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en); // R7
endmodule

bind sched_walker sw_checker #(.AW(AW), .FN_W(FN_W)) i_sw_checker (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .exec_start(exec_start),
  .busy(busy), .frame_num(frame_num)
);

// File: tb/test_sched_walker.sv
module test_sched_walker;
  localparam int AW  = 16;
  localparam int FLN = 8;
  localparam int FNW = 3;

  logic clk = 1'b0, rst = 1'b1, frame_tick = 1'b0;
  always #5 clk = ~clk;

  logic mem_rd_en, mem_wr_en, exec_start, busy;
  logic exec_done = 1'b0, exec_ok = 1'b0;
  logic [AW-1:0] mem_addr, exec_td_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [FNW-1:0] frame_num;

  sched_walker #(.AW(AW), .FL_ENTRIES(FLN), .FL_BASE(0)) i_sched_walker (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .exec_start(exec_start), .exec_td_addr(exec_td_addr),
    .exec_done(exec_done), .exec_ok(exec_ok),
    .busy(busy), .frame_num(frame_num)
  );

  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];
  end

  // Executor model: descriptors at 0xA0 and 0x150 fail, all others succeed.
  int dly = 3;
  int cnt = 0;
  logic [AW-1:0] ex_addr;
  always @(posedge clk) begin
    exec_done <= 1'b0;
    if (rst || frame_tick) cnt <= 0;
    else if (exec_start) begin
      cnt <= dly;
      ex_addr <= exec_td_addr;
    end else if (cnt == 1) begin
      cnt <= 0;
      exec_done <= 1'b1;
      exec_ok <= !(ex_addr == 16'h00A0 || ex_addr == 16'h0150);
    end else if (cnt > 1) cnt <= cnt - 1;
  end

  int n_exec = 0, n_wr = 0;
  logic [AW-1:0] elog [64];
  logic [AW-1:0] last_wa;
  logic [31:0] last_wd;
  always @(posedge clk) begin
    if (!rst && exec_start) begin
      elog[n_exec % 64] <= exec_td_addr;
      n_exec <= n_exec + 1;
    end
    if (!rst && mem_wr_en) begin
      last_wa <= mem_addr;
      last_wd <= mem_wdata;
      n_wr <= n_wr + 1;
    end
  end

  int total = 0, bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [31:0] v);
    mem[a >> 2] = v;
  endtask

  task automatic run_frame();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // {n_exec, td0, td1, n_writes, last write addr, last write data}
  localparam logic [95:0] VEC [11] = '{
    {16'd2, 16'h080, 16'h090, 16'd2, 16'h044, 16'h001}, // depth-first chain
    {16'd0, 16'h000, 16'h000, 16'd0, 16'h000, 16'h000}, // empty frame
    {16'd1, 16'h0B0, 16'h000, 16'd1, 16'h0C4, 16'h0E0}, // breadth-first
    {16'd1, 16'h0A0, 16'h000, 16'd0, 16'h000, 16'h000}, // frame-level TD fails
    {16'd1, 16'h0D0, 16'h000, 16'd1, 16'h124, 16'h001}, // nested queue head
    {16'd0, 16'h000, 16'h000, 16'd0, 16'h000, 16'h000}, // emptied queue
    {16'd2, 16'h150, 16'h190, 16'd1, 16'h184, 16'h001}, // fail then horizontal
    {16'd0, 16'h000, 16'h000, 16'd0, 16'h000, 16'h000},
    {16'd0, 16'h000, 16'h000, 16'd0, 16'h000, 16'h000}, // wrapped to entry 0
    {16'd0, 16'h000, 16'h000, 16'd0, 16'h000, 16'h000},
    {16'd0, 16'h000, 16'h000, 16'd0, 16'h000, 16'h000}  // inactive top TD
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // frame list
    put(32'h00, 32'h042); put(32'h04, 32'h001); put(32'h08, 32'h0C2);
    put(32'h0C, 32'h0A0); put(32'h10, 32'h102); put(32'h14, 32'h042);
    put(32'h18, 32'h142); put(32'h1C, 32'h001);
    // queue heads: word0 horizontal, word1 element
    put(32'h040, 32'h001); put(32'h044, 32'h080);
    put(32'h0C0, 32'h001); put(32'h0C4, 32'h0B0);
    put(32'h100, 32'h001); put(32'h104, 32'h122);
    put(32'h120, 32'h001); put(32'h124, 32'h0D0);
    put(32'h140, 32'h182); put(32'h144, 32'h150);
    put(32'h180, 32'h001); put(32'h184, 32'h190);
    // descriptors: word0 link, word1 bit23 active
    put(32'h080, 32'h094); put(32'h084, 32'h0080_0000);
    put(32'h090, 32'h001); put(32'h094, 32'h0080_0000);
    put(32'h0B0, 32'h0E0); put(32'h0B4, 32'h0080_0000);
    put(32'h0E0, 32'h001); put(32'h0E4, 32'h0000_0000);
    put(32'h0A0, 32'h001); put(32'h0A4, 32'h0080_0000);
    put(32'h0D0, 32'h001); put(32'h0D4, 32'h0080_0000);
    put(32'h150, 32'h164); put(32'h154, 32'h0080_0000);
    put(32'h160, 32'h001); put(32'h164, 32'h0080_0000);
    put(32'h190, 32'h001); put(32'h194, 32'h0080_0000);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 mem_rd_en", mem_rd_en, 0);
    chk("R1 exec_start", exec_start, 0);
    chk("R1 mem_wr_en", mem_wr_en, 0);
    chk("R1 frame_num", frame_num, 0);

    // R3 R4 R5 R7 R8 R9 R10 R11 exercised by the rows below
    for (int r = 0; r < 11; r++) begin
      automatic logic [95:0] v = VEC[r];
      automatic int be = n_exec;
      automatic int bw = n_wr;
      run_frame();
      chk("R2 frame index", frame_num, r % FLN);
      chk("R6 exec count", n_exec - be, v[95:80]);
      if (v[95:80] > 0) chk("R8 R9 first descriptor", elog[be % 64], v[79:64]);
      if (v[95:80] > 1) chk("R8 R9 second descriptor", elog[(be + 1) % 64], v[63:48]);
      chk("R7 write count", n_wr - bw, v[47:32]);
      if (v[47:32] > 0) begin
        chk("R7 R10 write address", last_wa, v[31:16]);
        chk("R7 R8 write data", last_wd, v[15:0]);
      end
    end
    chk("R10 outer queue element unchanged", mem[32'h104 >> 2], 32'h122);
    chk("R5 inactive TD leaves queue", mem[32'h0C4 >> 2], 32'h0E0);
    chk("R4 emptied queue element", mem[32'h044 >> 2], 32'h001);

    // R12: abort a walk while a transaction is pending
    put(32'h044, 32'h080);
    put(32'h0C, 32'h042);
    put(32'h10, 32'h042);
    dly = 20;
    begin
      automatic int be = n_exec;
      automatic int bw = n_wr;
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
      while (n_exec == be) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R12 no write before abort", n_wr - bw, 0);
      run_frame();
      chk("R12 frame after abort", frame_num, 4);
      chk("R12 exec count", n_exec - be, 3);
      chk("R12 writes only from restarted walk", n_wr - bw, 2);
      chk("R12 final element", mem[32'h044 >> 2], 32'h001);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule